// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. It watches the receive line on a sixteen-times oversampling enable and takes a falling level seen while idle as a possible start bit. It confirms that start bit half a bit later and then samples each data bit and the optional parity bit one bit period apart. Finally it samples the first stop bit. Each received character leaves the block right-justified, together with parity-error, framing-error and break flags, all qualified by a single-cycle valid strobe.

The frame format has to match the remote transmitter. Four control inputs set it: a two-bit word length code, a parity enable, a parity select and a parity force. The parity force turns the select into a fixed mark or space value. The block captures the format when it sees a start edge, so the format holds for the whole frame. The oversampling enable comes from an external baud generator.

The state machine has six states. RX_IDLE goes to RX_START when it sees a low line on a tick. RX_START goes to RX_DATA if the line is low at the start midpoint, and back to RX_IDLE if it is not. RX_DATA goes to RX_PARITY after the last data bit when parity is enabled, and to RX_STOP when it is not. RX_PARITY goes to RX_STOP. RX_STOP goes to RX_IDLE if the stop bit is high, and to RX_WAIT_HIGH if it is low. RX_WAIT_HIGH goes to RX_IDLE once the line is high again.

Top module: `serial_rx_unit`

## Requirements
- R1: The word length code picks the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Bits are assembled LSB first and placed at `rx_char[0]` upward. Bits above the word length read 0.
- R2: With `par_en`=0 no parity bit is expected: the stop bit directly follows the data, and `err_parity` stays 0.
- R3: With `par_en`=1 and `par_force`=0, `par_sel`=0 requires the data bits plus the parity bit to hold an odd number of ones, and `par_sel`=1 requires an even number. A mismatch sets `err_parity`.
- R4: With `par_en`=1 and `par_force`=1, `par_sel`=0 requires the parity bit to be 1 and `par_sel`=1 requires it to be 0. Any other value sets `err_parity`.
- R5: A start is accepted only if the synchronised line is still low on the 8th tick after the low level was first seen. A shorter low pulse returns the receiver to idle and produces no strobe.
- R6: Each data bit, the parity bit and the stop bit are sampled 16 ticks after the previous sample point, which puts them at bit centres.
- R7: `err_frame` is set when the stop bit samples 0. The receiver then waits for the line to go high before it accepts a new start.
- R8: `brk_seen` is set when every data bit, the parity bit (if enabled) and the stop bit all sample 0. It only ever appears together with `err_frame`.
- R9: `rx_valid` is high for exactly one clock cycle per received frame. The three flags are nonzero only in that cycle.
- R10: After reset the outputs are 0 and the receiver is idle. Control inputs all 0 mean 5 data bits with no parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| word_sel | input | 2 | Word length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit expected |
| par_sel | input | 1 | Parity select (odd/even or mark/space) |
| par_force | input | 1 | Fixed parity value instead of computed |
| rx_char | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a received frame |
| err_parity | output | 1 | Parity mismatch for this frame |
| err_frame | output | 1 | Stop bit sampled low |
| brk_seen | output | 1 | Whole frame low (break) |

## Verification
The bench sweeps all four word lengths against all five parity modes: off, odd, even, mark and space. Each combination gets several data patterns, namely all zeros, all ones and two mixed values, sent once with a correct parity bit and once with an inverted one. This tells bit ordering and truncation apart from parity arithmetic. Frames with a low stop bit are sent twice: once with nonzero data to separate a framing error from a break, and once fully zero, with and without a parity bit of 1, to show that the break needs every sampled bit low. These frames hold the line low for several bit periods after the stop bit, which exposes any premature restart. A short glitch probes start confirmation.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE      = 3'd0,
        RX_START     = 3'd1,
        RX_DATA      = 3'd2,
        RX_PARITY    = 3'd3,
        RX_STOP      = 3'd4,
        RX_WAIT_HIGH = 3'd5
    } rx_state_t;

    localparam int MIN_WORD = 5;
    localparam int MAX_WORD = 8;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] data,
    input  logic              par_bit,
    input  logic              par_sel,
    input  logic              par_force,
    output logic              par_bad
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^{data, par_bit};
        if (par_force) begin
            // select 0 expects mark, select 1 expects space
            par_bad = (par_bit == par_sel);
        end else begin
            par_bad = par_sel ? ones_odd : !ones_odd;
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [1:0] word_sel,
    input  logic       par_en,
    input  logic       par_sel,
    input  logic       par_force,
    output logic [7:0] rx_char,
    output logic       rx_valid,
    output logic       err_parity,
    output logic       err_frame,
    output logic       brk_seen
);
    localparam int CHAR_W = MAX_WORD;
    localparam int CNT_W  = $clog2(OSR);
    localparam int IDX_W  = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    rx_state_t         state_q, state_d;
    logic              rx_s;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [CHAR_W-1:0] data_q;
    logic              par_q;
    logic [1:0]        wl_q;
    logic              par_en_q, par_sel_q, par_force_q;
    logic              samp, mid_hit, par_bad, start_seen;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    serial_rx_parity #(.CHAR_W(CHAR_W)) u_par (
        .data     (data_q),
        .par_bit  (par_q),
        .par_sel  (par_sel_q),
        .par_force(par_force_q),
        .par_bad  (par_bad)
    );

    assign samp       = os_tick && (cnt_q == LAST_CNT);
    assign mid_hit    = os_tick && (cnt_q == MID_CNT);
    assign start_seen = (state_q == RX_IDLE) && os_tick && !rx_s;
    assign last_idx   = IDX_W'(MIN_WORD - 1) + IDX_W'(wl_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (start_seen) state_d = RX_START;
            RX_START:     if (mid_hit) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:      if (samp && idx_q == last_idx)
                              state_d = par_en_q ? RX_PARITY : RX_STOP;
            RX_PARITY:    if (samp) state_d = RX_STOP;
            RX_STOP:      if (samp) state_d = rx_s ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx_s) state_d = RX_IDLE;
            default:      state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // tick counter, bit index, captured data and format
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            idx_q       <= '0;
            data_q      <= '0;
            par_q       <= 1'b0;
            wl_q        <= 2'd0;
            par_en_q    <= 1'b0;
            par_sel_q   <= 1'b0;
            par_force_q <= 1'b0;
        end else begin
            if (state_q == RX_IDLE || state_q == RX_WAIT_HIGH) begin
                cnt_q <= '0;
            end else if (os_tick) begin
                if ((state_q == RX_START && cnt_q == MID_CNT) || cnt_q == LAST_CNT)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            if (start_seen) begin
                idx_q       <= '0;
                data_q      <= '0;
                par_q       <= 1'b0;
                wl_q        <= word_sel;
                par_en_q    <= par_en;
                par_sel_q   <= par_sel;
                par_force_q <= par_force;
            end
            if (state_q == RX_DATA && samp) begin
                data_q[idx_q] <= rx_s;
                idx_q         <= idx_q + 1'b1;
            end
            if (state_q == RX_PARITY && samp) begin
                par_q <= rx_s;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_char    <= '0;
            rx_valid   <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            brk_seen   <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            brk_seen   <= 1'b0;
            if (state_q == RX_STOP && samp) begin
                rx_valid   <= 1'b1;
                rx_char    <= data_q;
                err_parity <= par_en_q && par_bad;
                err_frame  <= !rx_s;
                brk_seen   <= !rx_s && (data_q == '0) && !(par_en_q && par_q);
            end
        end
    end
endmodule

// File: rtl/serial_rx_checks.sv
module serial_rx_checks
    import serial_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rx_char,
    input logic       rx_valid,
    input logic       err_parity,
    input logic       err_frame,
    input logic       brk_seen,
    input logic [1:0] wl_q,
    input logic       par_en_q,
    input rx_state_t  state_q
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R9

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity || err_frame || brk_seen) |-> rx_valid); // R9

    AST_BREAK_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        brk_seen |-> err_frame); // R8

    AST_NO_PARITY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |-> par_en_q); // R2

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_char >> (4'd5 + 4'(wl_q))) == 8'd0)); // R1

    AST_STROBE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state_q) == RX_STOP)); // R7
endmodule

bind serial_rx_unit serial_rx_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_char   (rx_char),
    .rx_valid  (rx_valid),
    .err_parity(err_parity),
    .err_frame (err_frame),
    .brk_seen  (brk_seen),
    .wl_q      (wl_q),
    .par_en_q  (par_en_q),
    .state_q   (state_q)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
    localparam int BIT_CYC = 32; // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] word_sel = 2'd0;
    logic       par_en = 1'b0, par_sel = 1'b0, par_force = 1'b0;
    logic [7:0] rx_char;
    logic       rx_valid, err_parity, err_frame, brk_seen;

    int n_chk = 0, n_bad = 0, vcount = 0;
    logic [7:0] cap_char;
    logic cap_pe, cap_fe, cap_bk;

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .word_sel(word_sel), .par_en(par_en), .par_sel(par_sel), .par_force(par_force),
        .rx_char(rx_char), .rx_valid(rx_valid), .err_parity(err_parity),
        .err_frame(err_frame), .brk_seen(brk_seen)
    );

    always #5 clk = ~clk;

    always @(negedge clk) os_tick <= ~os_tick;

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount   = vcount + 1;
            cap_char = rx_char;
            cap_pe   = err_parity;
            cap_fe   = err_frame;
            cap_bk   = brk_seen;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic run_frame(input int wl, input bit pe, input bit ps, input bit pf,
                             input logic [7:0] d, input bit pbit, input bit stopb,
                             input int extra_low);
        logic [7:0] mask, exp_char;
        bit exp_pe, exp_fe, exp_bk, good;
        mask     = 8'((1 << (5 + wl)) - 1);
        exp_char = d & mask;
        if (pf) good = !ps;
        else    good = ps ? (^exp_char) : !(^exp_char);
        exp_pe = pe && (pbit != good);
        exp_fe = !stopb;
        exp_bk = !stopb && exp_char == 8'd0 && !(pe && pbit);
        word_sel = 2'(wl); par_en = pe; par_sel = ps; par_force = pf;
        vcount = 0;
        drive_bit(1'b0);
        for (int i = 0; i < 5 + wl; i++) drive_bit(d[i]);
        if (pe) drive_bit(pbit);
        drive_bit(stopb);
        for (int k = 0; k < extra_low; k++) drive_bit(1'b0);
        rx_line = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        check(vcount == 1, "R9/R7 strobe count", vcount, 1);
        check(cap_char == exp_char, "R1/R6 character", cap_char, exp_char);
        check(cap_pe == exp_pe, pe ? (pf ? "R4 parity" : "R3 parity") : "R2 parity",
              cap_pe, exp_pe);
        check(cap_fe == exp_fe, "R7 framing", cap_fe, exp_fe);
        check(cap_bk == exp_bk, "R8 break", cap_bk, exp_bk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
        repeat (4) @(negedge clk);
        check(rx_valid == 0 && rx_char == 0 && err_parity == 0 && err_frame == 0
              && brk_seen == 0, "R10 reset outputs", {rx_valid, rx_char}, 0);
        rst_n = 1'b1;
        repeat (BIT_CYC) @(negedge clk);

        // R10: all-zero controls give 5 bits, no parity
        run_frame(0, 0, 0, 0, 8'h16, 0, 1, 0);

        // R1 R2 R3 R4 R6: sweep word length, parity mode, data, parity correctness
        for (int wl = 0; wl < 4; wl++) begin
            for (int mode = 0; mode < 5; mode++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int bad = 0; bad < ((mode == 0) ? 1 : 2); bad++) begin
                        bit pe, ps, pf, pb;
                        logic [7:0] m;
                        pe = (mode != 0);
                        ps = (mode == 2) || (mode == 4);
                        pf = (mode >= 3);
                        m  = pats[p] & 8'((1 << (5 + wl)) - 1);
                        if (pf) pb = !ps;
                        else    pb = ps ? (^m) : !(^m);
                        if (bad == 1) pb = !pb;
                        run_frame(wl, pe, ps, pf, pats[p], pb, 1, 0);
                    end
                end
            end
        end

        // R7: framing error with nonzero data, line held low afterwards
        for (int wl = 0; wl < 4; wl++) run_frame(wl, 0, 0, 0, 8'h5A, 0, 0, 3);

        // R8: break with and without parity; parity bit 1 prevents break
        run_frame(3, 0, 0, 0, 8'h00, 0, 0, 3);
        run_frame(1, 1, 1, 1, 8'h00, 0, 0, 3);
        run_frame(2, 1, 0, 0, 8'h00, 1, 0, 3);

        // R5: short low pulse is rejected
        vcount = 0;
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CYC) @(negedge clk);
        check(vcount == 0, "R5 glitch rejected", vcount, 0);
        run_frame(3, 1, 0, 0, 8'hC3, 1, 1, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule